// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This unit collects the completion and error pulses produced by the command and data paths of an SD/MMC host controller. Each pulse is captured in a sticky status flag. A flag can capture only while its bit in the capture-enable register is set. Software reads the flags through a small register port and clears them by writing ones. A read-only error summary flag reports whether any error flag is up. The summary is not gated by the capture-enable mask.

A separate line-enable register selects which flags may raise the single interrupt line. Capture and line generation are therefore independent: with the line-enable register at zero, flags still record events, but the line stays low. The line comes from a two-state machine. In `LINE_QUIET` the line is low. It moves to `LINE_RAISED` on the first clock edge at which any flag meets its line-enable bit. It returns to `LINE_QUIET` on the first edge at which no enabled flag remains. The line is high only in `LINE_RAISED`.

Top module: `sdirq_unit`

## Requirements
- R1: The nine event inputs map to status bits by position: bit 0 command complete, bit 1 transfer complete, bit 2 command timeout, bit 3 command CRC error, bit 4 command end-bit error, bit 5 command index error, bit 6 data timeout, bit 7 data CRC error, bit 8 data end-bit error. A pulse on an event sets its status bit at the next clock edge only when the same bit of the capture-enable register is 1. Otherwise the bit stays 0.
- R2: Status bit 15 is an error summary. It reads 1 whenever any of status bits 2 to 8 is set, whatever the capture-enable mask holds. Writing to it has no effect. It reads 0 once the last error bit has been cleared.
- R3: A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFF clears the whole register.
- R4: `irq_o` is high in the cycle after an edge at which some status bit (summary included) has its line-enable bit set. It is low in the cycle after an edge at which none does.
- R5: With the line-enable register at zero, status bits still latch events, but `irq_o` stays low. With both enable registers at zero, `irq_o` never rises.
- R6: Command complete (bit 0) and transfer complete (bit 1) are distinct bits. Both can be set and read together.
- R7: When an event pulse and a write-one-to-clear reach the same bit in the same cycle, the bit is set after that edge.
- R8: After reset, all three registers read 0 and `irq_o` is low.
- R9: Register map: address 0 is status, address 1 is capture-enable, and address 2 is line-enable. In capture-enable only bits 8:0 are held. In line-enable only bits 8:0 and bit 15 are held. All other bits, and all of address 3, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_i | input | 9 | Event pulses, one per status bit 8:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt line |

## Verification
A flag that captures or clears wrongly shows up on the status read in the very next cycle after the edge that updated it. A flag left stuck, or lost to a simultaneous clear, appears there too. A line machine left in the wrong state shows one cycle later on `irq_o`: it raises the line when line-enable is zero, or holds the line high after the last enabled flag is cleared. A summary flag that is masked or that clears on its own shows as bit 15 disagreeing with bits 2 to 8 in the same read.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;

    localparam int SDIRQ_EVENTS  = 9;
    localparam int SDIRQ_REG_W   = 16;
    localparam int SDIRQ_SUM_BIT = 15;
    localparam int SDIRQ_ERR_LO  = 2;

    typedef enum logic [1:0] {
        ADR_STATUS  = 2'd0,
        ADR_CAP_EN  = 2'd1,
        ADR_LINE_EN = 2'd2,
        ADR_SPARE   = 2'd3
    } sdirq_addr_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } sdirq_line_e;

endpackage

// File: rtl/sdirq_flag.sv
module sdirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic enable_i,
    input  logic clear_i,
    output logic flag_o
);

    logic flag_q;
    logic set_w;

    assign set_w = event_i & enable_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_w)
            flag_q <= 1'b1;
        else if (clear_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R1: no capture while disabled
    assert_no_set_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !flag_q) |=> !flag_q);

    // R7: an event beats a clear on the same edge
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && enable_i) |=> flag_q);

    // R3: a one clears the flag
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clear_i && !(event_i && enable_i)) |=> !flag_q);

    // R3: without a clear the flag holds
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear_i) |=> flag_q);

endmodule

// File: rtl/sdirq_enables.sv
module sdirq_enables #(
    parameter int NUM_EV  = 9,
    parameter int REG_W   = 16,
    parameter int SUM_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cap_i,
    input  logic              wr_line_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [NUM_EV-1:0] cap_en_o,
    output logic [REG_W-1:0]  line_en_o
);

    localparam logic [REG_W-1:0] LINE_MASK =
        REG_W'((1 << NUM_EV) - 1) | (REG_W'(1) << SUM_BIT);

    logic [NUM_EV-1:0] cap_q;
    logic [REG_W-1:0]  line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            line_q <= '0;
        end else begin
            if (wr_cap_i)
                cap_q <= wdata_i[NUM_EV-1:0];
            if (wr_line_i)
                line_q <= wdata_i & LINE_MASK;
        end
    end

    assign cap_en_o  = cap_q;
    assign line_en_o = line_q;

    // R9: unimplemented line-enable bits never hold a one
    assert_line_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_line_i |=> ((line_en_o & ~LINE_MASK) == '0));

endmodule

// File: rtl/sdirq_line_fsm.sv
module sdirq_line_fsm
    import sdirq_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] status_i,
    input  logic [REG_W-1:0] line_en_i,
    output logic             irq_o
);

    sdirq_line_e state_q, state_d;
    logic        pending_w;

    assign pending_w = |(status_i & line_en_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LINE_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending_w)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending_w) state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            LINE_QUIET:  irq_o = 1'b0;
            LINE_RAISED: irq_o = 1'b1;
        endcase
    end

    // R5: a zero line-enable register keeps the line low
    assert_line_low_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en_i == '0) |=> !irq_o);

    // R4: an enabled flag raises the line one cycle later
    assert_line_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & line_en_i)) |=> irq_o);

    // R4: no enabled flag drops the line one cycle later
    assert_line_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_i & line_en_i)) |=> !irq_o);

endmodule

// File: rtl/sdirq_unit.sv
module sdirq_unit
    import sdirq_pkg::*;
#(
    parameter int NUM_EV  = SDIRQ_EVENTS,
    parameter int REG_W   = SDIRQ_REG_W,
    parameter int SUM_BIT = SDIRQ_SUM_BIT,
    parameter int ERR_LO  = SDIRQ_ERR_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);

    sdirq_addr_e       addr_w;
    logic              wr_status, wr_cap, wr_line;
    logic [NUM_EV-1:0] cap_en;
    logic [REG_W-1:0]  line_en;
    logic [NUM_EV-1:0] flags;
    logic              summary;
    logic [REG_W-1:0]  status_full;

    assign addr_w = sdirq_addr_e'(reg_addr);

    always_comb begin
        wr_status = 1'b0;
        wr_cap    = 1'b0;
        wr_line   = 1'b0;
        unique case (addr_w)
            ADR_STATUS:  wr_status = reg_wr;
            ADR_CAP_EN:  wr_cap    = reg_wr;
            ADR_LINE_EN: wr_line   = reg_wr;
            ADR_SPARE:   ;
        endcase
    end

    sdirq_enables #(
        .NUM_EV  (NUM_EV),
        .REG_W   (REG_W),
        .SUM_BIT (SUM_BIT)
    ) u_enables (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cap_i  (wr_cap),
        .wr_line_i (wr_line),
        .wdata_i   (reg_wdata),
        .cap_en_o  (cap_en),
        .line_en_o (line_en)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
        sdirq_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .event_i  (ev_i[i]),
            .enable_i (cap_en[i]),
            .clear_i  (wr_status & reg_wdata[i]),
            .flag_o   (flags[i])
        );
    end

    assign summary = |flags[NUM_EV-1:ERR_LO];

    always_comb begin
        status_full          = '0;
        status_full[NUM_EV-1:0] = flags;
        status_full[SUM_BIT] = summary;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (addr_w)
            ADR_STATUS:  reg_rdata = status_full;
            ADR_CAP_EN:  reg_rdata[NUM_EV-1:0] = cap_en;
            ADR_LINE_EN: reg_rdata = line_en;
            ADR_SPARE:   reg_rdata = '0;
        endcase
    end

    sdirq_line_fsm #(
        .REG_W (REG_W)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_full),
        .line_en_i (line_en),
        .irq_o     (irq_o)
    );

    // R2: the summary cannot be cleared while an error flag stays up
    assert_summary_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_full[SUM_BIT] && !wr_status) |=> status_full[SUM_BIT]);

endmodule

// File: tb/sim_sdirq_unit.sv
module sim_sdirq_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  ev_i = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdirq_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [8:0]  ev;
        logic [8:0]  cap;
        logic [15:0] line;
        logic [15:0] exp_stat;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{9'h001, 9'h1FF, 16'h0001, 16'h0001, 1'b1},
        '{9'h003, 9'h1FF, 16'h0000, 16'h0003, 1'b0},
        '{9'h004, 9'h1FF, 16'h8000, 16'h8004, 1'b1},
        '{9'h1FF, 9'h000, 16'hFFFF, 16'h0000, 1'b0},
        '{9'h180, 9'h080, 16'h0100, 16'h8080, 1'b0},
        '{9'h002, 9'h002, 16'h0002, 16'h0002, 1'b1},
        '{9'h040, 9'h1FF, 16'h0040, 16'h8040, 1'b1},
        '{9'h1FF, 9'h1FF, 16'h0000, 16'h81FF, 1'b0}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [8:0] e);
        ev_i = e;
        @(negedge clk);
        ev_i = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd(2'd0, d); check("R8 status", d, 16'h0000);
        rd(2'd1, d); check("R8 cap-en", d, 16'h0000);
        rd(2'd2, d); check("R8 line-en", d, 16'h0000);
        check("R8 irq", {15'd0, irq_o}, 16'h0000);

        // R5 both enables zero: events never raise the line
        for (int k = 0; k < 6; k++) begin
            pulse(9'h1FF);
            check("R5 irq with enables zero", {15'd0, irq_o}, 16'h0000);
        end
        rd(2'd0, d); check("R1 nothing captured when disabled", d, 16'h0000);

        // R9 register map
        wr(2'd1, 16'hFFFF); rd(2'd1, d); check("R9 cap-en mask", d, 16'h01FF);
        wr(2'd2, 16'hFFFF); rd(2'd2, d); check("R9 line-en mask", d, 16'h81FF);
        wr(2'd3, 16'hFFFF); rd(2'd3, d); check("R9 spare reads zero", d, 16'h0000);
        wr(2'd2, 16'h0000);

        // Vector table: R1 R2 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            wr(2'd0, 16'hFFFF);
            wr(2'd1, {7'd0, VEC[v].cap});
            wr(2'd2, VEC[v].line);
            pulse(VEC[v].ev);
            rd(2'd0, d);
            check($sformatf("R1/R2/R6 vector %0d status", v), d, VEC[v].exp_stat);
            @(negedge clk);
            check($sformatf("R4/R5 vector %0d irq", v), {15'd0, irq_o}, {15'd0, VEC[v].exp_irq});
        end

        // R3 write-one-to-clear, R2 summary behaviour
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h01FF);
        wr(2'd0, 16'hFFFF);
        pulse(9'h1FF);
        rd(2'd0, d); check("R3 all set", d, 16'h81FF);
        wr(2'd0, 16'h0000); rd(2'd0, d); check("R3 zero write no change", d, 16'h81FF);
        wr(2'd0, 16'h8000); rd(2'd0, d); check("R2 summary not clearable", d, 16'h81FF);
        wr(2'd0, 16'h0004); rd(2'd0, d); check("R3 single clear", d, 16'h81FB);
        wr(2'd0, 16'h01F8); rd(2'd0, d); check("R2 summary falls", d, 16'h0003);
        wr(2'd0, 16'hFFFF); rd(2'd0, d); check("R3 clear all", d, 16'h0000);

        // R2 summary visible while its error source capture is later disabled
        pulse(9'h020);
        wr(2'd1, 16'h0000);
        rd(2'd0, d); check("R2 summary ignores mask", d, 16'h8020);
        wr(2'd1, 16'h01FF);
        wr(2'd0, 16'hFFFF);

        // R7 event and clear collide
        pulse(9'h008);
        ev_i = 9'h008; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0008;
        @(negedge clk);
        ev_i = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, d); check("R7 set bit stays on collision", d, 16'h8008);
        wr(2'd0, 16'hFFFF);
        ev_i = 9'h001; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0001;
        @(negedge clk);
        ev_i = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd0, d); check("R7 clear bit sets on collision", d, 16'h0001);

        // R4 line drop timing after clear
        wr(2'd2, 16'h0001);
        @(negedge clk);
        check("R4 line up", {15'd0, irq_o}, 16'h0001);
        wr(2'd0, 16'h0001);
        check("R4 line still up one cycle after clear", {15'd0, irq_o}, 16'h0001);
        @(negedge clk);
        check("R4 line down", {15'd0, irq_o}, 16'h0000);

        // R5 line-enable zero while status latched
        wr(2'd2, 16'h0000);
        pulse(9'h002);
        @(negedge clk);
        rd(2'd0, d); check("R5 status latches", d, 16'h0002);
        check("R5 line low", {15'd0, irq_o}, 16'h0000);

        finish_run();
    end

endmodule